// File: doc/BRIEF.md
# Byte-wide file-register execute unit

This block is the execute stage for byte-wide instructions that operate on a data-memory location in a small 8-bit accumulator machine. Each cycle in which an instruction is presented, it decodes the 16-bit word, forms the data-memory address from the 8-bit offset and either the bank register or the fixed access bank, and combines the working register with the operand fetched from that address. It then produces the 8-bit result and the new five-bit status word, and it raises one of two write strobes: one for the working register, one for the file location.

The surrounding pipeline supplies the operand already read from memory and the current status bits. It consumes the registered result, address, status and strobes one cycle later. Each operation updates its own subset of the status bits, and every bit outside that subset is passed through unchanged from the status input. Skips, branches, multiplication, instruction fetch and the memory array itself are handled elsewhere.

Top module: `byte_file_alu`

## Requirements
- R1: Instruction fields: bits 15:10 hold a 6-bit operation code, bit 9 the destination bit, bit 8 the bank-mode bit and bits 7:0 the file offset. The clear, set, negate and store-W forms instead use a 7-bit code in bits 15:9: 0110101, 0110100, 0110110 and 0110111 in that order.
- R2: For 6-bit codes, destination bit 0 raises `w_we` and destination bit 1 raises `f_we`. The 7-bit forms always raise `f_we`, and the two strobes are never high together.
- R3: With bank-mode bit 1 the address is {bank_sel, offset}. With bank-mode bit 0, `bank_sel` is ignored: offsets below ACC_SPLIT (default 60h) go to bank 0 and the rest go to the all-ones bank.
- R4: Status bit positions are C=0, DC=1, Z=2, OV=3, N=4. Code 001001 gives f+W, 001000 gives f+W+C and 001010 gives f+1. These set C to the carry out of bit 7, DC to the carry out of bit 3, OV to signed overflow, Z when the result is zero and N to result bit 7.
- R5: Code 010111 gives f-W, 010110 gives f-W-!C, 010101 gives W-f-!C, 000001 gives f-1 and 0110110 gives 0-f. These update all five bits, with C and DC reporting not-borrow out of bits 7 and 3.
- R6: Code 000101 gives AND, 000100 OR, 000110 XOR, 000111 the complement of f and 010100 gives f unchanged. These update only Z and N.
- R7: Code 001101 rotates f left through C and 001100 rotates it right through C; both update C, Z and N. Code 010001 rotates left and 010000 rotates right without C; both update only Z and N.
- R8: Code 001110 swaps the nibbles of f, 0110100 gives FFh and 0110111 gives W. None of these changes any status bit.
- R9: Code 0110101 gives 00h, sets Z and leaves the other four status bits unchanged.
- R10: Outputs appear one cycle after `instr_valid` and hold while it is low. Each valid instruction produces exactly one strobe cycle, and no strobe appears in the cycle after a cycle with `instr_valid` low.
- R11: Any other code raises neither strobe and passes `stat_in` unchanged to `stat_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction word |
| wreg_in | input | 8 | Working register value |
| bank_sel | input | BANK_W | Bank register value |
| fdata_in | input | 8 | Operand read from the addressed location |
| stat_in | input | 5 | Current status {N,OV,Z,DC,C} |
| result_q | output | 8 | Registered result |
| addr_q | output | BANK_W+8 | Registered data-memory address |
| stat_q | output | 5 | Registered new status |
| w_we | output | 1 | One-cycle write strobe for the working register |
| f_we | output | 1 | One-cycle write strobe for the file location |

## Verification
The hardest cases to reach are the nibble and sign boundaries of the subtract-with-borrow forms. There, DC and OV depend jointly on the incoming carry and on operand values such as 0Fh/10h and 7Fh/80h. The stimulus reaches them by sweeping every code over all 256 operand values, against a working-register set built from those boundary values, with both carry states. The destination, bank-mode, bank and unrelated status bits are varied from the loop indices at the same time. Expected flags come from integer subtraction and signed range tests rather than from an adder.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int DW     = 8;
  localparam int NFLAGS = 5;
  localparam int FL_C   = 0;
  localparam int FL_DC  = 1;
  localparam int FL_Z   = 2;
  localparam int FL_OV  = 3;
  localparam int FL_N   = 4;

  localparam logic [NFLAGS-1:0] UPD_ALL  = 5'b11111;
  localparam logic [NFLAGS-1:0] UPD_ZN   = 5'b10100;
  localparam logic [NFLAGS-1:0] UPD_CZN  = 5'b10101;
  localparam logic [NFLAGS-1:0] UPD_Z    = 5'b00100;
  localparam logic [NFLAGS-1:0] UPD_NONE = 5'b00000;

  typedef enum logic [4:0] {
    OP_ADD, OP_ADDC, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_INC, OP_DEC,
    OP_SUB, OP_SUBB, OP_SUBR, OP_SWAP, OP_RLC, OP_RRC, OP_RL, OP_RR,
    OP_MOVF, OP_CLR, OP_SET, OP_NEG, OP_MOVW, OP_NONE
  } alu_op_e;

  typedef struct packed {
    alu_op_e           op;
    logic              legal;
    logic              dest_f;
    logic [NFLAGS-1:0] upd;
  } dec_t;
endpackage

// File: rtl/bx_decode.sv
module bx_decode
  import byte_alu_pkg::*;
(
  input  logic [15:0] instr,
  output dec_t        dec
);
  logic [5:0] code6;
  logic       dbit;

  assign code6 = instr[15:10];
  assign dbit  = instr[9];

  always_comb begin
    dec.op     = OP_NONE;
    dec.legal  = 1'b1;
    dec.dest_f = dbit;
    dec.upd    = UPD_NONE;
    case (code6)
      6'b001001: begin dec.op = OP_ADD;  dec.upd = UPD_ALL; end
      6'b001000: begin dec.op = OP_ADDC; dec.upd = UPD_ALL; end
      6'b001010: begin dec.op = OP_INC;  dec.upd = UPD_ALL; end
      6'b000001: begin dec.op = OP_DEC;  dec.upd = UPD_ALL; end
      6'b010111: begin dec.op = OP_SUB;  dec.upd = UPD_ALL; end
      6'b010110: begin dec.op = OP_SUBB; dec.upd = UPD_ALL; end
      6'b010101: begin dec.op = OP_SUBR; dec.upd = UPD_ALL; end
      6'b000101: begin dec.op = OP_AND;  dec.upd = UPD_ZN;  end
      6'b000100: begin dec.op = OP_IOR;  dec.upd = UPD_ZN;  end
      6'b000110: begin dec.op = OP_XOR;  dec.upd = UPD_ZN;  end
      6'b000111: begin dec.op = OP_COM;  dec.upd = UPD_ZN;  end
      6'b010100: begin dec.op = OP_MOVF; dec.upd = UPD_ZN;  end
      6'b001101: begin dec.op = OP_RLC;  dec.upd = UPD_CZN; end
      6'b001100: begin dec.op = OP_RRC;  dec.upd = UPD_CZN; end
      6'b010001: begin dec.op = OP_RL;   dec.upd = UPD_ZN;  end
      6'b010000: begin dec.op = OP_RR;   dec.upd = UPD_ZN;  end
      6'b001110: begin dec.op = OP_SWAP; dec.upd = UPD_NONE; end
      6'b011010: begin
        dec.dest_f = 1'b1;
        if (dbit) begin dec.op = OP_CLR; dec.upd = UPD_Z; end
        else      begin dec.op = OP_SET; dec.upd = UPD_NONE; end
      end
      6'b011011: begin
        dec.dest_f = 1'b1;
        if (dbit) begin dec.op = OP_MOVW; dec.upd = UPD_NONE; end
        else      begin dec.op = OP_NEG;  dec.upd = UPD_ALL;  end
      end
      default: begin
        dec.legal  = 1'b0;
        dec.dest_f = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bx_addr.sv
module bx_addr #(
  parameter int         BANK_W    = 6,
  parameter logic [7:0] ACC_SPLIT = 8'h60,
  localparam int        ADDR_W    = BANK_W + 8
) (
  input  logic              banked,
  input  logic [7:0]        offset,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [ADDR_W-1:0] addr
);
  logic [BANK_W-1:0] acc_bank;

  assign acc_bank = (offset < ACC_SPLIT) ? {BANK_W{1'b0}} : {BANK_W{1'b1}};
  assign addr     = banked ? {bank_sel, offset} : {acc_bank, offset};
endmodule

// File: rtl/bx_datapath.sv
module bx_datapath
  import byte_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DW-1:0]     wv,
  input  logic [DW-1:0]     fv,
  input  logic              cin,
  output logic [DW-1:0]     res,
  output logic [NFLAGS-1:0] flg
);
  logic [DW-1:0] ax, ay;
  logic          aci;
  logic [DW:0]   sum9;
  logic [4:0]    lo5;
  logic          rot_c, use_rot_c;

  // Shared adder: every add/subtract form is x + y + ci
  always_comb begin
    ax  = fv;
    ay  = '0;
    aci = 1'b0;
    case (op)
      OP_ADD:  ay = wv;
      OP_ADDC: begin ay = wv;  aci = cin;  end
      OP_INC:  aci = 1'b1;
      OP_DEC:  ay = '1;
      OP_SUB:  begin ay = ~wv; aci = 1'b1; end
      OP_SUBB: begin ay = ~wv; aci = cin;  end
      OP_SUBR: begin ax = wv;  ay = ~fv; aci = cin; end
      OP_NEG:  begin ax = '0;  ay = ~fv; aci = 1'b1; end
      default: ;
    endcase
  end

  assign sum9 = {1'b0, ax} + {1'b0, ay} + {{DW{1'b0}}, aci};
  assign lo5  = {1'b0, ax[3:0]} + {1'b0, ay[3:0]} + {4'd0, aci};

  always_comb begin
    res       = sum9[DW-1:0];
    rot_c     = 1'b0;
    use_rot_c = 1'b0;
    case (op)
      OP_AND:  res = wv & fv;
      OP_IOR:  res = wv | fv;
      OP_XOR:  res = wv ^ fv;
      OP_COM:  res = ~fv;
      OP_MOVF: res = fv;
      OP_SWAP: res = {fv[3:0], fv[7:4]};
      OP_RLC:  begin res = {fv[6:0], cin}; rot_c = fv[7]; use_rot_c = 1'b1; end
      OP_RRC:  begin res = {cin, fv[7:1]}; rot_c = fv[0]; use_rot_c = 1'b1; end
      OP_RL:   res = {fv[6:0], fv[7]};
      OP_RR:   res = {fv[0], fv[7:1]};
      OP_CLR:  res = '0;
      OP_SET:  res = '1;
      OP_MOVW: res = wv;
      default: ;
    endcase
  end

  always_comb begin
    flg        = '0;
    flg[FL_C]  = use_rot_c ? rot_c : sum9[DW];
    flg[FL_DC] = lo5[4];
    flg[FL_OV] = (ax[DW-1] == ay[DW-1]) && (sum9[DW-1] != ax[DW-1]);
    flg[FL_Z]  = (res == '0);
    flg[FL_N]  = res[DW-1];
  end

  // R5: carry of f-W from the adder agrees with a magnitude compare
  always_comb begin
    if (op == OP_SUB) begin
      p_sub_carry_r5: assert (flg[FL_C] == (fv >= wv))
        else $error("subtract carry is not not-borrow");
    end
  end
endmodule

// File: rtl/byte_file_alu.sv
module byte_file_alu
  import byte_alu_pkg::*;
#(
  parameter int         BANK_W    = 6,
  parameter logic [7:0] ACC_SPLIT = 8'h60,
  localparam int        ADDR_W    = BANK_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic [7:0]        wreg_in,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [7:0]        fdata_in,
  input  logic [4:0]        stat_in,
  output logic [7:0]        result_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [4:0]        stat_q,
  output logic              w_we,
  output logic              f_we
);
  dec_t              dec;
  logic [DW-1:0]     res;
  logic [NFLAGS-1:0] flg, stat_nx;
  logic [ADDR_W-1:0] addr;

  bx_decode u_dec (.instr(instr), .dec(dec));

  bx_addr #(.BANK_W(BANK_W), .ACC_SPLIT(ACC_SPLIT)) u_addr (
    .banked(instr[8]), .offset(instr[7:0]), .bank_sel(bank_sel), .addr(addr)
  );

  bx_datapath u_dp (
    .op(dec.op), .wv(wreg_in), .fv(fdata_in), .cin(stat_in[FL_C]),
    .res(res), .flg(flg)
  );

  assign stat_nx = (stat_in & ~dec.upd) | (flg & dec.upd);

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      addr_q   <= '0;
      stat_q   <= '0;
      w_we     <= 1'b0;
      f_we     <= 1'b0;
    end else begin
      w_we <= instr_valid && dec.legal && !dec.dest_f;
      f_we <= instr_valid && dec.legal &&  dec.dest_f;
      if (instr_valid) begin
        result_q <= res;
        addr_q   <= addr;
        stat_q   <= stat_nx;
      end
    end
  end

  // R2: never both strobes
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !(w_we && f_we));

  // R2: AND routes by destination bit
  p_dest_and_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && instr_valid && instr[15:10] == 6'b000101) |->
      (w_we == !$past(instr[9])) && (f_we == $past(instr[9])));

  // R10: idle cycle produces no strobe
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !(w_we || f_we));

  // R3: low access offsets land in bank 0
  p_access_low_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && instr_valid && !instr[8] && instr[7:0] < ACC_SPLIT) |->
      addr_q[ADDR_W-1:8] == '0);

  // R8: nibble swap leaves status untouched
  p_swap_keep_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && instr_valid && instr[15:10] == 6'b001110) |->
      stat_q == $past(stat_in));
endmodule

// File: tb/test_byte_file_alu.sv
module test_byte_file_alu;
  localparam int BANK_W = 6;
  localparam int ADDR_W = BANK_W + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0] wreg_in = '0, fdata_in = '0;
  logic [BANK_W-1:0] bank_sel = '0;
  logic [4:0] stat_in = '0;
  logic [7:0] result_q;
  logic [ADDR_W-1:0] addr_q;
  logic [4:0] stat_q;
  logic w_we, f_we;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  byte_file_alu #(.BANK_W(BANK_W), .ACC_SPLIT(8'h60)) i_byte_file_alu (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .wreg_in(wreg_in), .bank_sel(bank_sel), .fdata_in(fdata_in),
    .stat_in(stat_in), .result_q(result_q), .addr_q(addr_q),
    .stat_q(stat_q), .w_we(w_we), .f_we(f_we)
  );

  function automatic logic [7:0] wpick(int i);
    case (i)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h0F; 3: return 8'h10;
      4: return 8'h7F; 5: return 8'h80; 6: return 8'hFE; default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [15:0] mkins(int i, logic d, logic a, logic [7:0] f);
    logic [5:0] c6;
    case (i)
      0: c6 = 6'b001001; 1: c6 = 6'b001000; 2: c6 = 6'b001010; 3: c6 = 6'b000001;
      4: c6 = 6'b010111; 5: c6 = 6'b010110; 6: c6 = 6'b010101; 7: c6 = 6'b000101;
      8: c6 = 6'b000100; 9: c6 = 6'b000110; 10: c6 = 6'b000111; 11: c6 = 6'b010100;
      12: c6 = 6'b001101; 13: c6 = 6'b001100; 14: c6 = 6'b010001; 15: c6 = 6'b010000;
      16: c6 = 6'b001110; default: c6 = 6'b001111;
    endcase
    case (i)
      17: return {7'b0110101, a, f};
      18: return {7'b0110100, a, f};
      19: return {7'b0110110, a, f};
      20: return {7'b0110111, a, f};
      default: return {c6, d, a, f};
    endcase
  endfunction

  // add-type flags from integer sums
  task automatic addk(input int x, input int y, input int ci,
                      output logic [7:0] r, output logic c, dc, ov);
    int s, sx, sy;
    s  = x + y + ci;
    sx = (x > 127) ? x - 256 : x;
    sy = (y > 127) ? y - 256 : y;
    r  = 8'(s);
    c  = (s > 255);
    dc = ((x % 16) + (y % 16) + ci) > 15;
    ov = (sx + sy + ci > 127) || (sx + sy + ci < -128);
  endtask

  // subtract-type flags: C and DC are not-borrow
  task automatic subk(input int x, input int y, input int bi,
                      output logic [7:0] r, output logic c, dc, ov);
    int s, sx, sy;
    s  = x - y - bi;
    sx = (x > 127) ? x - 256 : x;
    sy = (y > 127) ? y - 256 : y;
    r  = 8'(s);
    c  = (s >= 0);
    dc = ((x % 16) - (y % 16) - bi) >= 0;
    ov = (sx - sy - bi > 127) || (sx - sy - bi < -128);
  endtask

  task automatic apply(input logic [15:0] ins, input logic [7:0] w, f,
                       input logic [4:0] st, input logic [BANK_W-1:0] bk);
    logic [7:0] r;
    logic c, dc, ov, legal, destf, cin;
    logic [4:0] upd, fl, est;
    logic [ADDR_W-1:0] ea;
    string req;
    logic [28:0] act, exp, msk;
    int fi, wi;
    instr = ins; wreg_in = w; fdata_in = f; stat_in = st; bank_sel = bk;
    instr_valid = 1'b1;
    fi = int'(f); wi = int'(w); cin = st[0];
    r = 8'h00; c = 0; dc = 0; ov = 0; upd = 5'b00000;
    legal = 1'b1; destf = ins[9];
    case (ins[15:10])
      6'b001001: begin addk(fi, wi, 0, r, c, dc, ov); upd = 5'b11111; req = "R4"; end
      6'b001000: begin addk(fi, wi, int'(cin), r, c, dc, ov); upd = 5'b11111; req = "R4"; end
      6'b001010: begin addk(fi, 1, 0, r, c, dc, ov); upd = 5'b11111; req = "R4"; end
      6'b000001: begin subk(fi, 1, 0, r, c, dc, ov); upd = 5'b11111; req = "R5"; end
      6'b010111: begin subk(fi, wi, 0, r, c, dc, ov); upd = 5'b11111; req = "R5"; end
      6'b010110: begin subk(fi, wi, int'(!cin), r, c, dc, ov); upd = 5'b11111; req = "R5"; end
      6'b010101: begin subk(wi, fi, int'(!cin), r, c, dc, ov); upd = 5'b11111; req = "R5"; end
      6'b000101: begin r = w & f; upd = 5'b10100; req = "R6"; end
      6'b000100: begin r = w | f; upd = 5'b10100; req = "R6"; end
      6'b000110: begin r = w ^ f; upd = 5'b10100; req = "R6"; end
      6'b000111: begin r = 8'(255 - fi); upd = 5'b10100; req = "R6"; end
      6'b010100: begin r = f; upd = 5'b10100; req = "R6"; end
      6'b001101: begin r = 8'((fi * 2) % 256 + int'(cin)); c = (fi >= 128); upd = 5'b10101; req = "R7"; end
      6'b001100: begin r = 8'(fi / 2 + 128 * int'(cin)); c = (fi % 2 == 1); upd = 5'b10101; req = "R7"; end
      6'b010001: begin r = 8'((fi * 2) % 256 + fi / 128); upd = 5'b10100; req = "R7"; end
      6'b010000: begin r = 8'(fi / 2 + 128 * (fi % 2)); upd = 5'b10100; req = "R7"; end
      6'b001110: begin r = 8'((fi % 16) * 16 + fi / 16); req = "R8"; end
      6'b011010: begin
        destf = 1'b1;
        if (ins[9]) begin r = 8'h00; upd = 5'b00100; req = "R9"; end
        else        begin r = 8'hFF; req = "R8"; end
      end
      6'b011011: begin
        destf = 1'b1;
        if (ins[9]) begin r = w; req = "R8"; end
        else begin subk(0, fi, 0, r, c, dc, ov); upd = 5'b11111; req = "R5"; end
      end
      default: begin legal = 1'b0; destf = 1'b0; req = "R11"; end
    endcase
    fl  = {r[7], ov, (r == 8'h00), dc, c};
    est = (st & ~upd) | (fl & upd);
    if (ins[8]) ea = {bk, ins[7:0]};
    else if (ins[7:0] < 8'h60) ea = {{BANK_W{1'b0}}, ins[7:0]};
    else ea = {{BANK_W{1'b1}}, ins[7:0]};
    @(posedge clk);
    #1;
    act = {w_we, f_we, result_q, addr_q, stat_q};
    exp = {legal && !destf, legal && destf, r, ea, est};
    msk = legal ? '1 : {2'b11, 8'h00, {ADDR_W{1'b0}}, 5'b11111};
    nvec++;
    if ((act & msk) != (exp & msk)) begin
      nbad++;
      $display("FAIL %s R1 R2 R3 R10 ins=%h w=%h f=%h st=%b: actual=%h expected=%h",
               req, ins, w, f, st, act & msk, exp & msk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [28:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    // R10: reset state all zero, no strobes
    nvec++;
    if ({w_we, f_we, result_q, addr_q, stat_q} != '0) begin
      nbad++;
      $display("FAIL R10 reset actual=%h expected=0",
               {w_we, f_we, result_q, addr_q, stat_q});
    end
    @(negedge clk);

    for (int oi = 0; oi < 22; oi++)
      for (int fi = 0; fi < 256; fi++)
        for (int wi = 0; wi < 8; wi++)
          for (int cb = 0; cb < 2; cb++) begin
            logic [7:0] f8;
            logic [2:0] w3;
            logic d, a;
            logic [4:0] st;
            f8 = 8'(fi); w3 = 3'(wi);
            d  = f8[0] ^ w3[0];
            a  = f8[3] ^ w3[1] ^ cb[0];
            st = {f8[6] ^ w3[1], f8[5], f8[4] ^ w3[0], f8[7] ^ w3[2], cb[0]};
            apply(mkins(oi, d, a, f8), wpick(wi), f8, st, BANK_W'(fi * 5 + wi));
          end

    // R10: idle cycle holds outputs and drops strobes
    apply(mkins(0, 1'b0, 1'b1, 8'h33), 8'h11, 8'h22, 5'b00000, 6'h2A);
    held = {w_we, f_we, result_q, addr_q, stat_q};
    instr_valid = 1'b0; instr = mkins(9, 1'b1, 1'b0, 8'hF0);
    fdata_in = 8'h5A; stat_in = 5'b11111;
    @(posedge clk); #1;
    nvec++;
    if ({w_we, f_we, result_q, addr_q, stat_q} != {2'b00, held[26:0]}) begin
      nbad++;
      $display("FAIL R10 idle actual=%h expected=%h",
               {w_we, f_we, result_q, addr_q, stat_q}, {2'b00, held[26:0]});
    end
    @(negedge clk);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule